// File: doc/BRIEF.md
# Reloading Local Timer with Interrupt Routing

This block is a free-running countdown timer that sits on a simple word-wide register port. Software sets a 28-bit reload value and two enables. While the timer runs, the count drops by one each clock. Each time the count runs out, the timer raises a sticky pending flag and starts over from the reload value.

The interrupt is delivered as a level on exactly one of eight lines. A 3-bit route code picks the line. The lower two bits name a core from 0 to 3. The top bit chooses between the fast (FIQ) and the normal (IRQ) request of that core.

A separate command register carries two write-one actions. One action acknowledges the pending flag. The other restarts the count from the reload value. Both actions work whether or not the timer is running.

Top module: `lcl_tmr_route`

## Requirements
- R1: The control word at offset 0x34 holds the reload value in bits 27:0, the run enable in bit 28 and the interrupt enable in bit 29. A write stores these fields. A read returns them, with bit 30 reading as 0.
- R2: Bit 31 of the control word reads as the pending flag. Writing bit 31 of the control word has no effect on the flag. Once set, the flag stays set until it is cleared through the command word.
- R3: While the run enable is 1, the count drops by one each clock. A clock edge that finds the count at 1 or 0 sets the pending flag and loads the reload value. A reload value N of 1 or more therefore gives one expiry every N clocks, and a reload value of 0 gives an expiry on every clock.
- R4: The pending flag sets on expiry even when the interrupt enable is 0.
- R5: Writing the command word at offset 0x38 with bit 31 set clears the pending flag.
- R6: Writing the command word with bit 30 set loads the count with the reload value. This works whether the run enable is 0 or 1.
- R7: If a clear command and an expiry fall on the same clock edge, the pending flag remains 1.
- R8: While the run enable is 0, the count holds its value and no expiry occurs.
- R9: The route code is held in bits 2:0 at offset 0x24, and the other bits read as 0. Codes 0 to 3 select irq_o[0] to irq_o[3]. Codes 4 to 7 select fiq_o[0] to fiq_o[3].
- R10: The selected line equals (pending AND interrupt enable) as a level. The other seven lines are 0.
- R11: Bits 29:0 of a command-word write are ignored. The command word reads as 0, and reads at any other offset, or with rd_en low, return 0.
- R12: After reset, all register fields, the count and the pending flag are 0, and all eight lines are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe, sampled on the rising edge |
| rd_en | input | 1 | Read strobe; rdata is 0 when it is low |
| addr | input | ADDR_W | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Combinational read data |
| irq_o | output | 4 | Normal interrupt request, one per core |
| fiq_o | output | 4 | Fast interrupt request, one per core |

## Verification
The assertions assume that the bus never presents two register accesses in one clock, so a command and a control write can never coincide. They also assume that the strobes are clean levels held across each rising edge. The bench drives one access per cycle at the falling edge, and it keeps reload values small so that expiries are frequent. This lets the stimulus reach clear/expiry collisions and reloads while the timer is stopped, together with all eight route codes.

// File: rtl/lcl_tmr_route.sv
module lcl_tmr_route #(
  parameter int ADDR_W    = 8,
  parameter int CNT_W     = 28,
  parameter int OFS_ROUTE = 'h24,
  parameter int OFS_CTRL  = 'h34,
  parameter int OFS_CMD   = 'h38
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic [3:0]        irq_o,
  output logic [3:0]        fiq_o
);
  localparam int BIT_RUN = 28;
  localparam int BIT_IEN = 29;
  localparam int BIT_RLD = 30;
  localparam int BIT_CLR = 31;

  logic [CNT_W-1:0] rld_val, cnt;
  logic             run, ien, pend;
  logic [2:0]       route;

  wire wr_ctrl  = wr_en && addr == ADDR_W'(OFS_CTRL);
  wire wr_cmd   = wr_en && addr == ADDR_W'(OFS_CMD);
  wire wr_route = wr_en && addr == ADDR_W'(OFS_ROUTE);
  wire cmd_rld  = wr_cmd && wdata[BIT_RLD];
  wire cmd_clr  = wr_cmd && wdata[BIT_CLR];
  wire expire   = run && cnt <= CNT_W'(1);
  wire line     = pend && ien;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rld_val <= '0;
      run     <= 1'b0;
      ien     <= 1'b0;
      route   <= '0;
    end else begin
      if (wr_ctrl) begin
        rld_val <= wdata[CNT_W-1:0];
        run     <= wdata[BIT_RUN];
        ien     <= wdata[BIT_IEN];
      end
      if (wr_route) route <= wdata[2:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      pend <= 1'b0;
    end else begin
      if (cmd_rld || expire) cnt <= rld_val;
      else if (run)          cnt <= cnt - CNT_W'(1);
      if (expire)            pend <= 1'b1;
      else if (cmd_clr)      pend <= 1'b0;
    end
  end

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      if (addr == ADDR_W'(OFS_CTRL))
        rdata = {pend, 1'b0, ien, run, 28'(rld_val)};
      else if (addr == ADDR_W'(OFS_ROUTE))
        rdata = {29'd0, route};
    end
  end

  for (genvar c = 0; c < 4; c++) begin : g_core
    assign irq_o[c] = line && !route[2] && route[1:0] == 2'(c);
    assign fiq_o[c] = line &&  route[2] && route[1:0] == 2'(c);
  end

  assert_expiry_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && cnt == CNT_W'(1)) |=> pend);
  assert_reload_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_rld |=> cnt == $past(rld_val));
  assert_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !cmd_clr) |=> pend);
  assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_clr && !expire) |=> !pend);
  assert_collide_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_clr && expire) |=> pend);
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !cmd_rld) |=> ($stable(cnt) && ($past(pend) || !pend)));
  assert_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fiq_o, irq_o}) && ((pend && ien) == |{fiq_o, irq_o}));
endmodule

// File: tb/lcl_tmr_route_tb_top.sv
module lcl_tmr_route_tb_top;
  localparam int A_ROUTE = 'h24, A_CTRL = 'h34, A_CMD = 'h38;

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [3:0]  irq_o, fiq_o;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  lcl_tmr_route dut_i (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq_o(irq_o), .fiq_o(fiq_o));

  logic [27:0] m_rld = '0, m_cnt = '0;
  logic m_run = 0, m_ien = 0, m_pend = 0;
  logic [2:0] m_route = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_rld <= '0; m_cnt <= '0; m_run <= 0; m_ien <= 0; m_pend <= 0; m_route <= '0;
    end else begin
      automatic bit ex = m_run && (m_cnt == 0 || m_cnt == 1);
      automatic bit rl = wr_en && addr == A_CMD && wdata[30];
      automatic bit cl = wr_en && addr == A_CMD && wdata[31];
      if (rl || ex) m_cnt <= m_rld;
      else if (m_run) m_cnt <= m_cnt - 1;
      m_pend <= ex ? 1'b1 : (cl ? 1'b0 : m_pend);
      if (wr_en && addr == A_CTRL) begin
        m_rld <= wdata[27:0]; m_run <= wdata[28]; m_ien <= wdata[29];
      end
      if (wr_en && addr == A_ROUTE) m_route <= wdata[2:0];
    end
  end

  function automatic logic [7:0] exp_lines(logic [2:0] r, logic act);
    return act ? (8'd1 << r) : 8'd0;
  endfunction

  function automatic logic [31:0] exp_rd(logic re, logic [7:0] a);
    if (!re) return 0;
    if (a == A_CTRL) return {m_pend, 1'b0, m_ien, m_run, m_rld};
    if (a == A_ROUTE) return {29'd0, m_route};
    return 0;
  endfunction

  task automatic check(string tag);
    logic [7:0]  el = exp_lines(m_route, m_pend && m_ien);
    logic [31:0] er = exp_rd(rd_en, addr);
    checks++;
    if ({fiq_o, irq_o} !== el || rdata !== er) begin
      fails++;
      $display("FAIL %s lines=%h exp=%h rdata=%h exp=%h", tag, {fiq_o, irq_o}, el, rdata, er);
    end
  endtask

  task automatic step(bit we, bit re, int a, logic [31:0] d, string tag);
    wr_en = we; rd_en = re; addr = 8'(a); wdata = d;
    @(negedge clk);
    check(tag);
  endtask

  task automatic idle(int n, int a, string tag);
    for (int i = 0; i < n; i++) step(0, 1, a, 0, tag);
  endtask

  initial begin
    #400000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R12 reset lines");
    rst_n = 1'b1;
    step(0, 1, A_CTRL, 0, "R12 reset ctrl");
    step(0, 1, A_ROUTE, 0, "R12 reset route");
    // R1 full write, pending bit RO
    step(1, 1, A_CTRL, 32'hFFFF_FFFF, "R1 write all ones");
    idle(2, A_CTRL, "R1 R2 readback");
    // stop timer, clear pending
    step(1, 1, A_CTRL, 32'h0000_0005, "R2 write bit31 zero keeps pend");
    step(1, 1, A_CMD, 32'h3FFF_FFFF, "R11 low bits ignored");
    idle(2, A_CTRL, "R11 pend still set");
    step(1, 1, A_CMD, 32'h8000_0000, "R5 clear");
    idle(1, A_CTRL, "R5 cleared");
    // R6 R8 reload while stopped then hold
    step(1, 1, A_CMD, 32'h4000_0000, "R6 reload stopped");
    idle(12, A_CTRL, "R8 stopped no expiry");
    // R3 R4 run with ien=0
    step(1, 1, A_CTRL, 32'h1000_0005, "R3 start");
    idle(20, A_CTRL, "R3 R4 period five");
    step(1, 1, A_CMD, 32'h8000_0000, "R5 clear running");
    step(1, 1, A_CTRL, 32'h0000_0005, "R8 stop mid count");
    idle(10, A_CTRL, "R8 hold");
    step(1, 1, A_CTRL, 32'h1000_0005, "R8 resume");
    idle(8, A_CTRL, "R8 resume finishes count");
    // R7 reload zero: expiry each cycle
    step(1, 1, A_CTRL, 32'h3000_0000, "R3 reload zero");
    idle(2, A_CTRL, "R3 every clock");
    step(1, 1, A_CMD, 32'h8000_0000, "R7 clear collides");
    idle(1, A_CTRL, "R7 pend kept");
    // R9 R10 every route code
    for (int r = 0; r < 8; r++) begin
      step(1, 1, A_ROUTE, 32'hFFFF_FFF8 | r, "R9 route write");
      idle(1, A_ROUTE, "R9 R10 routed line");
    end
    step(1, 1, A_CTRL, 32'h1000_0000, "R10 ien off gates");
    idle(2, A_CTRL, "R10 all low");
    step(0, 1, A_CMD, 0, "R11 cmd reads zero");
    step(0, 0, A_CTRL, 0, "R11 rd_en low");
    step(0, 1, 'h30, 0, "R11 other offset");
    // random mix
    for (int i = 0; i < 4000; i++) begin
      int k = $urandom_range(0, 9);
      int a = (k < 2) ? A_CTRL : (k < 4) ? A_CMD : (k < 5) ? A_ROUTE : A_CTRL;
      logic [31:0] d = $urandom;
      if (a == A_CTRL) d[27:0] = 28'($urandom_range(0, 12));
      step(k < 5, $urandom_range(0, 7) != 0, (k < 5) ? a : ($urandom_range(0, 1) ? A_ROUTE : A_CTRL),
           d, "R3 R5 R6 R7 R9 R10 random");
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule